// File: doc/BRIEF.md
# Four-Port Burst Read Arbiter

This block lets four clients share one burst-read channel of a memory controller. Each client raises a request and presents a start address and a burst length. The arbiter searches the clients in a rotating order and picks the first one that has a request with a nonzero length. It captures that client's address and length and issues a single memory-side request. It then waits for the burst to complete.

While a burst runs, the memory side's data-valid strobe, data word and finish flag reach only the granted client. Every other client sees them as zero. Clients keep their requests raised until they see finish, so a client that waits behind another burst is served later. After each finish the arbiter spends one idle cycle. The search then starts at the client after the one just served, which shares the channel in round-robin fashion.

Top module: `burst_rd_arbiter`

## Requirements
- R1: Out of reset, and in every cycle with no burst in progress, `mem_req` is low and all client valid, data and finish outputs are zero.
- R2: A client whose request is high but whose length is zero is never granted. `mem_req` stays low while such a client is the only requester.
- R3: After reset the search starts at client 0, so when all four clients request at once, client 0 is served first.
- R4: After a burst for client k finishes, the search starts at client (k+1) mod 4. With clients 0, 1 and 3 waiting after client 2 was served, the service order is 3, 0, 1.
- R5: `mem_addr` and `mem_len` equal the granted client's address and length. `mem_req` rises on the clock edge after the cycle in which the client became eligible while the arbiter was idle.
- R6: `mem_req` stays high until the first cycle in which `mem_valid` or `mem_finish` is high, and is low from the following edge on.
- R7: Client p's `cli_valid` bit (bit p), its data slice (bits p*DATA_W and up) and its `cli_finish` bit (bit p) follow the memory side only while p is granted. All other clients see zero.
- R8: `mem_addr` and `mem_len` do not change during a burst, even if the granted client or any other client changes its address or length.
- R9: After the cycle in which `mem_finish` is high, exactly one cycle passes with `mem_req` low. A waiting request then raises `mem_req` on the next edge.
- R10: A request that is held through another client's burst is served afterwards and is not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cli_req | input | NUM_PORTS | Request per client, held until finish |
| cli_len | input | NUM_PORTS*LEN_W | Burst length per client, client p in slice p |
| cli_addr | input | NUM_PORTS*ADDR_W | Start address per client, client p in slice p |
| cli_valid | output | NUM_PORTS | Read data valid, routed to the granted client |
| cli_data | output | NUM_PORTS*DATA_W | Read data, routed to the granted client's slice |
| cli_finish | output | NUM_PORTS | Burst finished, routed to the granted client |
| mem_req | output | 1 | Burst request to the memory side |
| mem_len | output | LEN_W | Granted burst length |
| mem_addr | output | ADDR_W | Granted start address |
| mem_valid | input | 1 | Read data valid from the memory side |
| mem_data | input | DATA_W | Read data from the memory side |
| mem_finish | input | 1 | Burst complete from the memory side |

## Verification
The hardest case to reach from the ports is the rotation after a finish. It shows only when several clients are already waiting and the last one served is not the highest-numbered client. The stimulus first serves client 2 on its own. It then raises clients 0, 1 and 3 together, so the order 3, 0, 1 separates a rotating search from a fixed-priority one. The stimulus also changes addresses in the middle of a burst and holds a zero-length request for many cycles, which shows that the captured parameters hold and that such a request is skipped.

// File: rtl/arb_pkg.sv
package arb_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_BUSY = 1'b1
   } arb_state_e;
endpackage

// File: rtl/arb_poll.sv
// Rotating search: first eligible client at or after the pointer.
module arb_poll #(
   parameter int NUM_PORTS = 4,
   parameter int LEN_W     = 10,
   localparam int IDX_W    = $clog2(NUM_PORTS)
) (
   input  logic [NUM_PORTS-1:0]       req,
   input  logic [NUM_PORTS*LEN_W-1:0] len,
   input  logic [IDX_W-1:0]           ptr,
   output logic                       found,
   output logic [IDX_W-1:0]           pick
);
   logic [NUM_PORTS-1:0] elig;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_elig
      assign elig[p] = req[p] && (len[p*LEN_W +: LEN_W] != '0);
   end

   always_comb begin
      found = 1'b0;
      pick  = '0;
      for (int k = 0; k < NUM_PORTS; k++) begin
         int j;
         j = int'(ptr) + k;
         if (j >= NUM_PORTS) j = j - NUM_PORTS;
         if (!found && elig[j]) begin
            found = 1'b1;
            pick  = IDX_W'(j);
         end
      end
   end
endmodule

// File: rtl/arb_ctrl.sv
// Grant state machine, captured burst parameters and rotation pointer.
module arb_ctrl
   import arb_pkg::*;
#(
   parameter int NUM_PORTS = 4,
   parameter int LEN_W     = 10,
   parameter int ADDR_W    = 24,
   localparam int IDX_W    = $clog2(NUM_PORTS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        found,
   input  logic [IDX_W-1:0]            pick,
   input  logic [NUM_PORTS*LEN_W-1:0]  cli_len,
   input  logic [NUM_PORTS*ADDR_W-1:0] cli_addr,
   input  logic                        mem_valid,
   input  logic                        mem_finish,
   output logic [IDX_W-1:0]            ptr,
   output logic                        busy,
   output logic [IDX_W-1:0]            grant,
   output logic                        mem_req,
   output logic [LEN_W-1:0]            mem_len,
   output logic [ADDR_W-1:0]           mem_addr
);
   arb_state_e state_q;
   logic [IDX_W-1:0] next_ptr;

   assign busy     = (state_q == ST_BUSY);
   assign next_ptr = (grant == IDX_W'(NUM_PORTS - 1)) ? '0 : grant + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         ptr      <= '0;
         grant    <= '0;
         mem_req  <= 1'b0;
         mem_len  <= '0;
         mem_addr <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (found) begin
                  state_q  <= ST_BUSY;
                  grant    <= pick;
                  mem_req  <= 1'b1;
                  mem_len  <= cli_len[pick*LEN_W +: LEN_W];
                  mem_addr <= cli_addr[pick*ADDR_W +: ADDR_W];
               end
            end
            ST_BUSY: begin
               if (mem_valid || mem_finish) mem_req <= 1'b0;
               if (mem_finish) begin
                  state_q <= ST_IDLE;
                  ptr     <= next_ptr;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/arb_route.sv
// Return-path steering to the granted client; others are held at zero.
module arb_route #(
   parameter int NUM_PORTS = 4,
   parameter int DATA_W    = 32,
   localparam int IDX_W    = $clog2(NUM_PORTS)
) (
   input  logic                        busy,
   input  logic [IDX_W-1:0]            grant,
   input  logic                        mem_valid,
   input  logic [DATA_W-1:0]           mem_data,
   input  logic                        mem_finish,
   output logic [NUM_PORTS-1:0]        cli_valid,
   output logic [NUM_PORTS*DATA_W-1:0] cli_data,
   output logic [NUM_PORTS-1:0]        cli_finish
);
   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic sel;
      assign sel           = busy && (grant == IDX_W'(p));
      assign cli_valid[p]  = sel && mem_valid;
      assign cli_finish[p] = sel && mem_finish;
      assign cli_data[p*DATA_W +: DATA_W] = (sel && mem_valid) ? mem_data : '0;
   end
endmodule

// File: rtl/burst_rd_arbiter.sv
module burst_rd_arbiter #(
   parameter int NUM_PORTS = 4,
   parameter int LEN_W     = 10,
   parameter int ADDR_W    = 24,
   parameter int DATA_W    = 32,
   localparam int IDX_W    = $clog2(NUM_PORTS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_PORTS-1:0]        cli_req,
   input  logic [NUM_PORTS*LEN_W-1:0]  cli_len,
   input  logic [NUM_PORTS*ADDR_W-1:0] cli_addr,
   output logic [NUM_PORTS-1:0]        cli_valid,
   output logic [NUM_PORTS*DATA_W-1:0] cli_data,
   output logic [NUM_PORTS-1:0]        cli_finish,
   output logic                        mem_req,
   output logic [LEN_W-1:0]            mem_len,
   output logic [ADDR_W-1:0]           mem_addr,
   input  logic                        mem_valid,
   input  logic [DATA_W-1:0]           mem_data,
   input  logic                        mem_finish
);
   if (NUM_PORTS < 2) begin : g_bad_ports
      $error("burst_rd_arbiter: NUM_PORTS must be at least 2");
   end
   if (LEN_W < 1 || ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("burst_rd_arbiter: widths must be positive");
   end

   logic             found;
   logic [IDX_W-1:0] pick;
   logic [IDX_W-1:0] ptr;
   logic             busy;
   logic [IDX_W-1:0] grant;

   arb_poll #(.NUM_PORTS(NUM_PORTS), .LEN_W(LEN_W)) u_poll (
      .req   (cli_req),
      .len   (cli_len),
      .ptr   (ptr),
      .found (found),
      .pick  (pick)
   );

   arb_ctrl #(.NUM_PORTS(NUM_PORTS), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .found      (found),
      .pick       (pick),
      .cli_len    (cli_len),
      .cli_addr   (cli_addr),
      .mem_valid  (mem_valid),
      .mem_finish (mem_finish),
      .ptr        (ptr),
      .busy       (busy),
      .grant      (grant),
      .mem_req    (mem_req),
      .mem_len    (mem_len),
      .mem_addr   (mem_addr)
   );

   arb_route #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_route (
      .busy       (busy),
      .grant      (grant),
      .mem_valid  (mem_valid),
      .mem_data   (mem_data),
      .mem_finish (mem_finish),
      .cli_valid  (cli_valid),
      .cli_data   (cli_data),
      .cli_finish (cli_finish)
   );
endmodule

// File: rtl/burst_rd_arbiter_chk.sv
module burst_rd_arbiter_chk #(
   parameter int NUM_PORTS = 4,
   parameter int LEN_W     = 10,
   parameter int ADDR_W    = 24,
   localparam int IDX_W    = $clog2(NUM_PORTS)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 busy,
   input logic [IDX_W-1:0]     grant,
   input logic [NUM_PORTS-1:0] cli_valid,
   input logic [NUM_PORTS-1:0] cli_finish,
   input logic                 mem_req,
   input logic [LEN_W-1:0]     mem_len,
   input logic [ADDR_W-1:0]    mem_addr,
   input logic                 mem_valid,
   input logic                 mem_finish
);
   // R1: nothing is driven outward while no burst is running
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req && cli_valid == '0 && cli_finish == '0));

   // R2: a freshly issued request never carries a zero length
   a_r2_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> (mem_len != '0));

   // R6: the request drops on the edge after the first response
   a_r6_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && (mem_valid || mem_finish)) |=> !mem_req);

   // R7: return strobes reach at most one client
   a_r7_onehot_route: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cli_valid) && $onehot0(cli_finish));

   // R8: captured parameters and grant hold for the whole burst
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !mem_finish) |=> ($stable(mem_addr) && $stable(mem_len) && $stable(grant)));

   // R9: one idle cycle follows every finish
   a_r9_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mem_finish) |=> (!busy && !mem_req));
endmodule

bind burst_rd_arbiter burst_rd_arbiter_chk #(
   .NUM_PORTS(NUM_PORTS), .LEN_W(LEN_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .grant      (grant),
   .cli_valid  (cli_valid),
   .cli_finish (cli_finish),
   .mem_req    (mem_req),
   .mem_len    (mem_len),
   .mem_addr   (mem_addr),
   .mem_valid  (mem_valid),
   .mem_finish (mem_finish)
);

// File: tb/burst_rd_arbiter_test.sv
module burst_rd_arbiter_test;
   localparam int NP = 4;
   localparam int LW = 10;
   localparam int AW = 24;
   localparam int DW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [NP-1:0]    req = '0;
   logic [LW-1:0]    len_a  [NP];
   logic [AW-1:0]    addr_a [NP];
   logic [NP*LW-1:0] cli_len;
   logic [NP*AW-1:0] cli_addr;
   logic [NP-1:0]    cli_valid, cli_finish;
   logic [NP*DW-1:0] cli_data;
   logic             mem_req;
   logic [LW-1:0]    mem_len;
   logic [AW-1:0]    mem_addr;
   logic             mem_valid = 1'b0, mem_finish = 1'b0;
   logic [DW-1:0]    mem_data = '0;

   for (genvar p = 0; p < NP; p++) begin : g_pack
      assign cli_len[p*LW +: LW]  = len_a[p];
      assign cli_addr[p*AW +: AW] = addr_a[p];
   end

   burst_rd_arbiter #(.NUM_PORTS(NP), .LEN_W(LW), .ADDR_W(AW), .DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .cli_req(req), .cli_len(cli_len), .cli_addr(cli_addr),
      .cli_valid(cli_valid), .cli_data(cli_data), .cli_finish(cli_finish),
      .mem_req(mem_req), .mem_len(mem_len), .mem_addr(mem_addr),
      .mem_valid(mem_valid), .mem_data(mem_data), .mem_finish(mem_finish)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      for (int c = 0; c < 100000; c++) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
      end
   end

   task automatic set_port(int p, logic [LW-1:0] l, logic [AW-1:0] a);
      len_a[p] = l; addr_a[p] = a;
   endtask

   // Memory model: serve one burst, expecting client p. Checks R5 R6 R7 R8.
   task automatic serve(int p, bit perturb);
      int w = 0;
      logic [AW-1:0] a0;
      logic [LW-1:0] l0;
      logic [DW-1:0] exp_d;
      while (!mem_req && w < 200) begin @(negedge clk); w++; end
      check("R10 request served", 128'(mem_req), 128'(1));
      a0 = addr_a[p]; l0 = len_a[p];
      check("R5 grant addr", 128'(mem_addr), 128'(a0));
      check("R5 grant len", 128'(mem_len), 128'(l0));
      @(negedge clk);
      check("R6 req held before data", 128'(mem_req), 128'(1));
      for (int b = 0; b < int'(l0); b++) begin
         exp_d = DW'(a0) + DW'(b);
         mem_valid = 1'b1; mem_data = exp_d;
         #1;
         check("R7 valid routed", 128'(cli_valid), 128'(1 << p));
         check("R7 data routed", 128'(cli_data), 128'(exp_d) << (p * DW));
         if (perturb && b == 0) begin
            for (int q = 0; q < NP; q++) addr_a[q] = addr_a[q] ^ 24'h0F0F0F;
            len_a[p] = len_a[p] + 3'd5;
         end
         @(negedge clk);
         check("R6 req dropped after data", 128'(mem_req), 128'(0));
         if (perturb) begin
            check("R8 addr held", 128'(mem_addr), 128'(a0));
            check("R8 len held", 128'(mem_len), 128'(l0));
         end
      end
      mem_valid = 1'b0; mem_data = '0; mem_finish = 1'b1;
      req[p] = 1'b0;
      #1;
      check("R7 finish routed", 128'(cli_finish), 128'(1 << p));
      @(negedge clk);
      mem_finish = 1'b0;
      check("R9 idle cycle after finish", 128'(mem_req), 128'(0));
      check("R1 quiet while idle", 128'({cli_valid, cli_finish}), 128'(0));
   endtask

   task automatic t_reset();
      check("R1 reset mem_req", 128'(mem_req), 128'(0));
      check("R1 reset returns", 128'({cli_valid, cli_finish, cli_data}), 128'(0));
   endtask

   task automatic t_fixed_order();
      for (int p = 0; p < NP; p++) set_port(p, LW'(2 + p), AW'(24'h100 * (p + 1)));
      req = 4'b1111;
      @(negedge clk);
      check("R3 first grant client 0", 128'(mem_addr), 128'(24'h100));
      serve(0, 0);
      for (int p = 1; p < NP; p++) begin
         @(negedge clk);
         check("R9 next req after one idle", 128'(mem_req), 128'(1));
         check("R3 sweep order", 128'(mem_addr), 128'(addr_a[p]));
         serve(p, 0);
      end
   endtask

   task automatic t_zero_len();
      set_port(1, '0, 24'hABC);
      req[1] = 1'b1;
      for (int c = 0; c < 12; c++) begin
         @(negedge clk);
         check("R2 zero length ignored", 128'(mem_req), 128'(0));
      end
      set_port(3, 10'd3, 24'h3000);
      req[3] = 1'b1;
      @(negedge clk);
      check("R2 skip zero-length client", 128'(mem_addr), 128'(24'h3000));
      serve(3, 0);
      req[1] = 1'b0;
   endtask

   task automatic t_round_robin();
      set_port(2, 10'd2, 24'h2200);
      req[2] = 1'b1;
      @(negedge clk);
      serve(2, 1);
      set_port(0, 10'd1, 24'h0A0);
      set_port(1, 10'd2, 24'h1A0);
      set_port(3, 10'd1, 24'h3A0);
      req = 4'b1011;
      @(negedge clk);
      check("R4 rotation starts after client 2", 128'(mem_addr), 128'(24'h3A0));
      serve(3, 0);
      @(negedge clk);
      check("R4 then client 0", 128'(mem_addr), 128'(24'h0A0));
      serve(0, 0);
      @(negedge clk);
      check("R10 waiting client 1 kept", 128'(mem_addr), 128'(24'h1A0));
      serve(1, 0);
   endtask

   initial begin
      for (int p = 0; p < NP; p++) set_port(p, '0, '0);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fixed_order();
      t_zero_len();
      t_round_robin();
      repeat (3) @(negedge clk);
      done = 1;
      summary();
   end
endmodule